// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the condition and mode flags of a small 8-bit processor. Six flags are stored: negative, overflow, decimal mode, interrupt disable, zero and carry. Each flag can be changed in four ways. A per-flag set strobe forces it to 1. A per-flag clear strobe forces it to 0. The ALU can write it through a per-flag write-enable and value pair. A parallel byte load writes all six flags at once, as when status is pulled back from the stack or restored on return from an interrupt.

Two byte views come out of the block. The read view has the fixed bit 5 at 1 and bit 4 at 0. The push view is the byte the stack logic writes to memory. It is the read view, except that bit 4 carries the break indication. No storage element exists for that bit; its value is derived from the reason for the push.

Reset is synchronous and active low. It sets interrupt disable and clears every other stored flag, so the read view reads 0x24.

Top module: `cpu_status_reg`

## Requirements
- R1: In the cycle after a clock edge sampled with `rst_n` low, `status_byte` is 0x24 and only `flag_i` is 1, whatever the other inputs are doing.
- R2: Bit 5 is 1 in both `status_byte` and `push_byte` at all times.
- R3: Bit 4 of `status_byte` is always 0. No stored break bit exists, and a load with byte bit 4 set does not make it 1.
- R4: `push_byte` equals `status_byte` with bit 4 replaced. Bit 4 is 1 when `push_by_irq` is 0 (break or push-status instruction) and 0 when `push_by_irq` is 1 (interrupt). The view follows `push_by_irq` without a clock edge.
- R5: Strobe and ALU vectors use index 0 = carry, 1 = zero, 2 = interrupt disable, 3 = decimal, 4 = overflow, 5 = negative. When bit k of `set_flag` is 1 and there is no load, flag k is 1 after the next edge. Setting carry from reset gives 0x25; setting zero and decimal after that gives 0x2F.
- R6: When bit k of `clr_flag` is 1, `set_flag[k]` is 0 and there is no load, flag k is 0 after the next edge.
- R7: When set and clear are both asserted for the same flag in the same cycle, the set wins.
- R8: When `alu_we[k]` is 1 and there is no load, set or clear for flag k, flag k takes `alu_val[k]` after the next edge.
- R9: A set or clear strobe for a flag takes priority over an ALU write to that flag in the same cycle.
- R10: On `load_en`, the stored flags take byte bits 7 (N), 6 (V), 3 (D), 2 (I), 1 (Z) and 0 (C) of `load_byte`. Bits 5 and 4 of the byte are ignored.
- R11: A load takes priority over every set, clear and ALU write in the same cycle.
- R12: A flag with no load, strobe or ALU write keeps its value across the edge.
- R13: The six individual flag outputs always agree with the matching bits of `status_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_flag | input | 6 | Per-flag set strobes (index per R5) |
| clr_flag | input | 6 | Per-flag clear strobes |
| alu_we | input | 6 | Per-flag ALU write enables |
| alu_val | input | 6 | Per-flag ALU values |
| load_en | input | 1 | Parallel byte load strobe |
| load_byte | input | 8 | Byte to load (layout per R10) |
| push_by_irq | input | 1 | 1 when the push is caused by an interrupt |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_d | output | 1 | Decimal mode flag |
| flag_i | output | 1 | Interrupt disable flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| status_byte | output | 8 | Read view of the register |
| push_byte | output | 8 | Byte to write to the stack |

## Verification
The bench builds the block with its default reset pattern, in which only interrupt disable is set, so the 0x24 reset value and the 0x25 and 0x2F set sequence can be checked directly. A chained vector table moves the register through every source of change. It includes the conflicting-request rows for load against strobes, set against clear, and strobe against ALU, and it alternates the push reason so that both break encodings are seen. Directed steps then apply reset while strobes are active and confirm that the register holds its value through idle cycles.

// File: rtl/status_pkg.sv
// Shared constants and helpers for the processor status register.
// Assumes an 8-bit status byte holding six stored flags.
package status_pkg;
    localparam int STAT_W    = 8;
    localparam int NUM_FLAGS = 6;
    localparam int FIXED_POS = 5;
    localparam int BRK_POS   = 4;

    // Flag index order in all strobe vectors.
    localparam int IDX_C = 0;
    localparam int IDX_Z = 1;
    localparam int IDX_I = 2;
    localparam int IDX_D = 3;
    localparam int IDX_V = 4;
    localparam int IDX_N = 5;

    // Byte bit position of stored flag k.
    function automatic int byte_pos(input int k);
        return (k < 4) ? k : k + 2;
    endfunction
endpackage

// File: rtl/status_flag_cell.sv
// One stored status flag with prioritized update sources.
// Priority: load, then set, then clear, then ALU write; otherwise hold.
module status_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_en,
    input  logic ld_val,
    input  logic set_s,
    input  logic clr_s,
    input  logic we,
    input  logic val,
    output logic q
);
    // Update the stored bit from the highest-priority active source.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RST_VAL;
        else if (ld_en)  q <= ld_val;
        else if (set_s)  q <= 1'b1;
        else if (clr_s)  q <= 1'b0;
        else if (we)     q <= val;
    end

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> q == $past(ld_val));
    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && set_s) |=> q);
    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !set_s && clr_s) |=> !q);
    p_alu_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !set_s && !clr_s && we) |=> q == $past(val));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !set_s && !clr_s && !we) |=> $stable(q));
endmodule

// File: rtl/status_pack.sv
// Formats stored flags into the read view and the stack push view.
// Assumes flags arrive in package index order.
module status_pack
    import status_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic                 push_by_irq,
    output logic [STAT_W-1:0]    rd_byte,
    output logic [STAT_W-1:0]    push_byte
);
    // Place stored flags, force the fixed bit, leave break clear.
    always_comb begin
        rd_byte            = '0;
        for (int k = 0; k < NUM_FLAGS; k++) rd_byte[byte_pos(k)] = flags[k];
        rd_byte[FIXED_POS] = 1'b1;
    end

    // Push view: break bit encodes the push reason.
    always_comb begin
        push_byte          = rd_byte;
        push_byte[BRK_POS] = ~push_by_irq;
    end

    // Views must agree outside bit 4.
    always_comb begin
        a_views_r4: assert ((push_byte & ~8'h10) == rd_byte);
        a_fixed_r2: assert (push_byte[FIXED_POS] && rd_byte[FIXED_POS]);
    end
endmodule

// File: rtl/cpu_status_reg.sv
// Processor status register: six stored flags, fixed bit 5, break bit
// synthesized only in the push view. Synchronous active-low reset.
module cpu_status_reg
    import status_pkg::*;
#(
    parameter logic [NUM_FLAGS-1:0] RESET_FLAGS = 6'b000100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_flag,
    input  logic [NUM_FLAGS-1:0] clr_flag,
    input  logic [NUM_FLAGS-1:0] alu_we,
    input  logic [NUM_FLAGS-1:0] alu_val,
    input  logic                 load_en,
    input  logic [STAT_W-1:0]    load_byte,
    input  logic                 push_by_irq,
    output logic                 flag_n,
    output logic                 flag_v,
    output logic                 flag_d,
    output logic                 flag_i,
    output logic                 flag_z,
    output logic                 flag_c,
    output logic [STAT_W-1:0]    status_byte,
    output logic [STAT_W-1:0]    push_byte
);
    localparam logic [STAT_W-1:0] RESET_READ = 8'h24;

    logic [NUM_FLAGS-1:0] flags;

    genvar g;
    generate
        for (g = 0; g < NUM_FLAGS; g++) begin : g_cell
            status_flag_cell #(.RST_VAL(RESET_FLAGS[g])) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .ld_en  (load_en),
                .ld_val (load_byte[byte_pos(g)]),
                .set_s  (set_flag[g]),
                .clr_s  (clr_flag[g]),
                .we     (alu_we[g]),
                .val    (alu_val[g]),
                .q      (flags[g])
            );
        end
    endgenerate

    status_pack u_pack (
        .flags       (flags),
        .push_by_irq (push_by_irq),
        .rd_byte     (status_byte),
        .push_byte   (push_byte)
    );

    // Drive individual flag outputs.
    always_comb begin
        flag_c = flags[IDX_C];
        flag_z = flags[IDX_Z];
        flag_i = flags[IDX_I];
        flag_d = flags[IDX_D];
        flag_v = flags[IDX_V];
        flag_n = flags[IDX_N];
    end

    // Remember that the previous edge was a reset edge.
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst_n;

    p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q == 1'b0) |-> status_byte == RESET_READ);
    p_no_brk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[BRK_POS] == 1'b0);
    p_fields_r13: assert property (@(posedge clk) disable iff (!rst_n)
        {flag_n, flag_v, flag_d, flag_i, flag_z, flag_c} ==
        {status_byte[7:6], status_byte[3:0]});
endmodule

// File: tb/sim_cpu_status_reg.sv
`timescale 1ns/100ps
module sim_cpu_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] set_flag = '0, clr_flag = '0, alu_we = '0, alu_val = '0;
    logic       load_en = 1'b0;
    logic [7:0] load_byte = '0;
    logic       push_by_irq = 1'b0;
    logic       flag_n, flag_v, flag_d, flag_i, flag_z, flag_c;
    logic [7:0] status_byte, push_byte;

    int n_cmp = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    cpu_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .set_flag(set_flag), .clr_flag(clr_flag),
        .alu_we(alu_we), .alu_val(alu_val), .load_en(load_en),
        .load_byte(load_byte), .push_by_irq(push_by_irq),
        .flag_n(flag_n), .flag_v(flag_v), .flag_d(flag_d), .flag_i(flag_i),
        .flag_z(flag_z), .flag_c(flag_c),
        .status_byte(status_byte), .push_byte(push_byte)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       ld;
        logic [7:0] ldb;
        logic [5:0] st;
        logic [5:0] cl;
        logic [5:0] we;
        logic [5:0] va;
        logic       irq;
        logic [7:0] e_rd;
        logic [7:0] e_push;
    } vec_t;

    // Chained from the reset state 0x24.
    localparam vec_t VECS [11] = '{
        '{4'd5,  1'b0, 8'h00, 6'b000001, 6'b000000, 6'b000000, 6'b000000, 1'b0, 8'h25, 8'h35}, // R5 set C, R4
        '{4'd5,  1'b0, 8'h00, 6'b001010, 6'b000000, 6'b000000, 6'b000000, 1'b1, 8'h2F, 8'h2F}, // R5 set Z,D, R4
        '{4'd6,  1'b0, 8'h00, 6'b000000, 6'b000100, 6'b000000, 6'b000000, 1'b0, 8'h2B, 8'h3B}, // R6 clear I
        '{4'd7,  1'b0, 8'h00, 6'b100000, 6'b100000, 6'b000000, 6'b000000, 1'b1, 8'hAB, 8'hAB}, // R7 set beats clear
        '{4'd8,  1'b0, 8'h00, 6'b000000, 6'b000000, 6'b110011, 6'b010010, 1'b0, 8'h6A, 8'h7A}, // R8 ALU write
        '{4'd9,  1'b0, 8'h00, 6'b000000, 6'b000001, 6'b000001, 6'b000001, 1'b1, 8'h6A, 8'h6A}, // R9 clear beats ALU
        '{4'd11, 1'b1, 8'hFF, 6'b000000, 6'b111111, 6'b000000, 6'b000000, 1'b0, 8'hEF, 8'hFF}, // R11 R10 R3
        '{4'd11, 1'b1, 8'h10, 6'b111111, 6'b000000, 6'b000000, 6'b000000, 1'b1, 8'h20, 8'h20}, // R11 R3
        '{4'd12, 1'b0, 8'h00, 6'b000000, 6'b000000, 6'b000000, 6'b000000, 1'b0, 8'h20, 8'h30}, // R12 R2
        '{4'd10, 1'b1, 8'h24, 6'b000000, 6'b000000, 6'b111111, 6'b111111, 1'b1, 8'h24, 8'h24}, // R10 R11
        '{4'd8,  1'b0, 8'h00, 6'b000000, 6'b000000, 6'b100000, 6'b100000, 1'b0, 8'hA4, 8'hB4}  // R8
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_fields(input string req);
        check8(req, {flag_n, flag_v, 2'b10, flag_d, flag_i, flag_z, flag_c}, status_byte);
    endtask

    task automatic idle_inputs();
        set_flag = '0; clr_flag = '0; alu_we = '0; alu_val = '0;
        load_en = 1'b0; load_byte = '0;
    endtask

    initial begin : watchdog
        #(5.0 * 20000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        string tag;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check8("R1 reset read", status_byte, 8'h24);
        check8("R1 flag_i", {7'b0, flag_i}, 8'h01);
        check_fields("R13 after reset");

        foreach (VECS[i]) begin
            load_en = VECS[i].ld; load_byte = VECS[i].ldb;
            set_flag = VECS[i].st; clr_flag = VECS[i].cl;
            alu_we = VECS[i].we; alu_val = VECS[i].va;
            @(negedge clk);
            idle_inputs();
            push_by_irq = VECS[i].irq;
            #0.1;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check8({tag, " read"}, status_byte, VECS[i].e_rd);
            check8({tag, " push R4"}, push_byte, VECS[i].e_push);
            check_fields({tag, " R13"});
        end

        // R4: push view follows push_by_irq with no edge.
        push_by_irq = 1'b1; #0.5;
        check8("R4 irq push", push_byte, 8'hA4);
        push_by_irq = 1'b0; #0.5;
        check8("R4 brk push", push_byte, 8'hB4);

        // R12: several idle cycles keep the value.
        repeat (3) @(negedge clk);
        check8("R12 hold", status_byte, 8'hA4);

        // R1: reset wins over active strobes and load.
        set_flag = 6'b111111; load_en = 1'b1; load_byte = 8'hFF; rst_n = 1'b0;
        @(negedge clk);
        idle_inputs(); rst_n = 1'b1;
        check8("R1 reset under strobes", status_byte, 8'h24);
        check8("R2 push after reset", push_byte, 8'h34);

        // R5: documented sequence from reset.
        set_flag = 6'b000001;
        @(negedge clk);
        set_flag = 6'b001010;
        check8("R5 carry from reset", status_byte, 8'h25);
        @(negedge clk);
        idle_inputs();
        check8("R5 zero and decimal", status_byte, 8'h2F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule